// File: doc/BRIEF.md
# Supervisory Reset Controller

This block keeps a processor in reset until its supply, its operator and its own software all allow it to run. It drives two complementary reset outputs from four causes: reset release at power-up, a power-fail flag from an external voltage comparator, an active-low pushbutton, and a watchdog. The watchdog expects regular high-to-low transitions on a strobe input. Everything runs from one free-running clock. A one-cycle `tick_ms` enable marks each millisecond, and every duration is counted in ticks.

The power-fail flag, the button and the strobe are asynchronous, so each of them passes through a two-flop synchronizer. A debounce filter then cleans the button. A reset stays active for as long as its cause is present. After the cause goes away, reset is held for a fixed stretch before it releases. A new cause that arrives during the stretch starts the stretch again once that cause clears. While reset is active the watchdog stays loaded with its full period. It starts counting down when reset releases, and a 2-bit select chooses one of three periods.

Top module: `sup_reset_ctrl`

## Requirements
- R1: `sys_rst` and `sys_rst_n` are always complements. During `rst_n` low, `sys_rst` is 1.
- R2: While the synchronized `pwr_fail` is 1, `sys_rst` stays 1. When `rst_n` is released, and again after `pwr_fail` clears, `sys_rst` falls on exactly the `HOLD_TICKS`-th tick (default 250) that follows.
- R3: `btn_n` low for `DEB_TICKS` (default 20) consecutive ticks makes `sys_rst` 1 on the clock after the last of those ticks. A low pulse that covers fewer ticks has no effect.
- R4: After the button is released, the debounced level returns high after `DEB_TICKS` ticks. `sys_rst` then falls on the `HOLD_TICKS`-th tick after that, so the release takes `DEB_TICKS + HOLD_TICKS` ticks in total.
- R5: The watchdog period in ticks is set by `wd_sel`: 2'b00 gives `WD_TICKS_0` (150), 2'b01 gives `WD_TICKS_1` (600), and both 2'b10 and 2'b11 give `WD_TICKS_2` (1200).
- R6: While `sys_rst` is 1 the watchdog stays loaded with its full period and cannot expire, and strobe edges have no effect. With no strobe edges, `sys_rst` rises again exactly one period of ticks after it falls.
- R7: A 1-to-0 transition on `strobe` while reset is inactive reloads the full period. The next expiry then comes one full period after that edge. Rising edges and steady levels do not reload.
- R8: On expiry, `sys_rst` rises on that tick's clock edge and falls `HOLD_TICKS` ticks later. After that release the watchdog starts again from its full period.
- R9: A new cause during a reset stretch cancels the count. `sys_rst` then falls `HOLD_TICKS` ticks after the new cause clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset at power-up |
| tick_ms | input | 1 | One-cycle millisecond enable |
| pwr_fail | input | 1 | Power-fail flag from the voltage comparator, asynchronous, active high |
| btn_n | input | 1 | Pushbutton, asynchronous, active low |
| strobe | input | 1 | Watchdog strobe, asynchronous; falling edges reload |
| wd_sel | input | 2 | Watchdog period select |
| sys_rst | output | 1 | Reset to the processor, active high |
| sys_rst_n | output | 1 | Reset to the processor, active low |

## Verification
Faults show up as durations between output edges, measured in ticks. A stretch counter that loses its count or is not cleared by a new cause moves the release of `sys_rst` by one or more ticks. A watchdog that is not reloaded, or that counts during reset, moves the next rising edge away from exactly one period after the release or the strobe edge. That edge comes within one watchdog period. A debounce counter that does not clear on a short pulse gives a reset edge the bench does not expect, within `DEB_TICKS` ticks.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // period select codes; the spare code behaves as the long setting
  typedef enum logic [1:0] {
    WD_SHORT = 2'b00,
    WD_MID   = 2'b01,
    WD_LONG  = 2'b10,
    WD_SPARE = 2'b11
  } wd_sel_e;

  // watchdog period in ticks for a select code
  function automatic int unsigned wd_period(input logic [1:0] sel,
                                            input int unsigned p0,
                                            input int unsigned p1,
                                            input int unsigned p2);
    case (sel)
      WD_SHORT: return p0;
      WD_MID:   return p1;
      default:  return p2;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q_sync <= RST_VAL;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int unsigned DEB_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level,
  output logic clean
);
  localparam int unsigned DW = (DEB_TICKS < 2) ? 1 : $clog2(DEB_TICKS + 1);
  localparam logic [DW-1:0] LAST = DW'(DEB_TICKS - 1);

  logic [DW-1:0] run_cnt;

  // the new level is taken only after DEB_TICKS ticks in a row that differ
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean   <= 1'b1;
      run_cnt <= '0;
    end else if (level == clean) begin
      run_cnt <= '0;
    end else if (tick) begin
      if (run_cnt == LAST) begin
        clean   <= level;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sup_hold.sv
module sup_hold #(
  parameter int unsigned HOLD_TICKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cause,
  output logic rst_q,
  output logic rst_nq
);
  localparam int unsigned HW = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] LAST = HW'(HOLD_TICKS - 1);

  logic [HW-1:0] cnt, cnt_nxt;
  logic          act_nxt;

  // any cause clears the stretch count; counting runs only with no cause
  always_comb begin
    act_nxt = rst_q;
    cnt_nxt = cnt;
    if (cause) begin
      act_nxt = 1'b1;
      cnt_nxt = '0;
    end else if (rst_q && tick) begin
      if (cnt == LAST) begin
        act_nxt = 1'b0;
        cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end
  end

  // each output polarity has its own flop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b1;
      rst_nq <= 1'b0;
      cnt    <= '0;
    end else begin
      rst_q  <= act_nxt;
      rst_nq <= ~act_nxt;
      cnt    <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
  import sup_pkg::*;
#(
  parameter int unsigned P0 = 150,
  parameter int unsigned P1 = 600,
  parameter int unsigned P2 = 1200,
  parameter int unsigned CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hold,
  input  logic          kick,
  input  logic [1:0]    sel,
  output logic          fire,
  output logic [CW-1:0] count
);
  logic [CW-1:0] period;

  assign period = CW'(wd_period(sel, P0, P1, P2));
  assign fire   = !hold && !kick && tick && (count == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= CW'(P0);
    end else if (hold || kick || fire) begin
      count <= period;
    end else if (tick) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 250,
  parameter int unsigned DEB_TICKS  = 20,
  parameter int unsigned WD_TICKS_0 = 150,
  parameter int unsigned WD_TICKS_1 = 600,
  parameter int unsigned WD_TICKS_2 = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       pwr_fail,
  input  logic       btn_n,
  input  logic       strobe,
  input  logic [1:0] wd_sel,
  output logic       sys_rst,
  output logic       sys_rst_n
);
  localparam int unsigned WD_MAX = max3(WD_TICKS_0, WD_TICKS_1, WD_TICKS_2);
  localparam int unsigned WD_CW  = $clog2(WD_MAX + 1);

  // named internal events
  logic             pf_sync, pb_sync, st_sync, st_prev;
  logic             st_fall, pb_clean, wd_fire, rst_cause;
  logic [WD_CW-1:0] wd_count;

  sup_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({pwr_fail, btn_n, strobe}),
    .q_sync  ({pf_sync, pb_sync, st_sync})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_prev <= 1'b0;
    else        st_prev <= st_sync;
  end

  assign st_fall = st_prev & ~st_sync;

  sup_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_ms),
    .level (pb_sync),
    .clean (pb_clean)
  );

  assign rst_cause = pf_sync | ~pb_clean | wd_fire;

  sup_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_ms),
    .cause  (rst_cause),
    .rst_q  (sys_rst),
    .rst_nq (sys_rst_n)
  );

  sup_watchdog #(
    .P0(WD_TICKS_0), .P1(WD_TICKS_1), .P2(WD_TICKS_2), .CW(WD_CW)
  ) u_wd (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_ms),
    .hold  (sys_rst),
    .kick  (st_fall),
    .sel   (wd_sel),
    .fire  (wd_fire),
    .count (wd_count)
  );
endmodule

// File: rtl/sup_reset_chk.sv
module sup_reset_chk
  import sup_pkg::*;
#(
  parameter int unsigned WD_TICKS_0 = 150,
  parameter int unsigned WD_TICKS_1 = 600,
  parameter int unsigned WD_TICKS_2 = 1200,
  parameter int unsigned CW         = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_ms,
  input logic [1:0]    wd_sel,
  input logic          sys_rst,
  input logic          sys_rst_n,
  input logic          pf_sync,
  input logic          pb_clean,
  input logic          st_fall,
  input logic          wd_fire,
  input logic          rst_cause,
  input logic [CW-1:0] wd_count
);
  AST_RST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst != sys_rst_n); // R1

  AST_PF_KEEPS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    pf_sync |=> sys_rst); // R2

  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> ($past(tick_ms) && !$past(rst_cause))); // R2

  AST_PB_PRESS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    !pb_clean |=> sys_rst); // R3

  AST_PB_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_clean != $past(pb_clean)) |-> $past(tick_ms)); // R3

  AST_WD_LOADED_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (int'(wd_count) ==
                 int'(wd_period($past(wd_sel), WD_TICKS_0, WD_TICKS_1, WD_TICKS_2)))); // R6

  AST_STROBE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fall && !sys_rst) |=> (int'(wd_count) ==
                 int'(wd_period($past(wd_sel), WD_TICKS_0, WD_TICKS_1, WD_TICKS_2)))); // R7

  AST_EXPIRY_RST: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> sys_rst); // R8
endmodule

bind sup_reset_ctrl sup_reset_chk #(
  .WD_TICKS_0(WD_TICKS_0), .WD_TICKS_1(WD_TICKS_1),
  .WD_TICKS_2(WD_TICKS_2), .CW(WD_CW)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_ms   (tick_ms),
  .wd_sel    (wd_sel),
  .sys_rst   (sys_rst),
  .sys_rst_n (sys_rst_n),
  .pf_sync   (pf_sync),
  .pb_clean  (pb_clean),
  .st_fall   (st_fall),
  .wd_fire   (wd_fire),
  .rst_cause (rst_cause),
  .wd_count  (wd_count)
);

// File: tb/test_sup_reset_ctrl.sv
module test_sup_reset_ctrl;
  localparam int HOLD = 8;
  localparam int DEB  = 3;
  localparam int WD0  = 10;
  localparam int WD1  = 20;
  localparam int WD2  = 40;

  logic       clk = 1'b0;
  logic       rst_n, tick_ms, pwr_fail, btn_n, strobe;
  logic [1:0] wd_sel;
  logic       sys_rst, sys_rst_n;

  sup_reset_ctrl #(
    .HOLD_TICKS(HOLD), .DEB_TICKS(DEB),
    .WD_TICKS_0(WD0), .WD_TICKS_1(WD1), .WD_TICKS_2(WD2)
  ) i_sup_reset_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pwr_fail(pwr_fail),
    .btn_n(btn_n), .strobe(strobe), .wd_sel(wd_sel),
    .sys_rst(sys_rst), .sys_rst_n(sys_rst_n)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0, comp_bad = 0;
  int tick_seen = 0, mark = 0, div = 0;
  bit prev_rst = 1'b1;

  typedef struct {
    bit    rise;
    int    ticks;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  // tick enable: one cycle in four, driven away from the active edge
  initial tick_ms = 1'b0;
  always @(negedge clk) begin
    div     = (div + 1) % 4;
    tick_ms = (div == 0);
  end
  always @(posedge clk) if (tick_ms) tick_seen++;

  // scoreboard monitor: each output edge is matched against the next expected item
  always @(negedge clk) begin
    if (sys_rst === sys_rst_n) comp_bad++;
    if (sys_rst !== prev_rst) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R8 unexpected edge: act sys_rst=%0b after %0d ticks, exp no edge",
                 sys_rst, tick_seen - mark);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (e.rise != sys_rst || (tick_seen - mark) != e.ticks) begin
          failures++;
          $display("FAIL %s: act edge=%0b ticks=%0d, exp edge=%0b ticks=%0d",
                   e.tag, sys_rst, tick_seen - mark, e.rise, e.ticks);
        end
      end
      mark     = tick_seen;
      prev_rst = sys_rst;
    end
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog expired: act cycles=%0d exp run to finish", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic push(input bit rise, input int ticks, input string tag);
    exp_t e;
    e.rise = rise; e.ticks = ticks; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk iff tick_ms);
      @(negedge clk);
    end
  endtask

  task automatic wait_empty();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic chk_level(input bit exp, input string tag);
    checks++;
    if (sys_rst !== exp || sys_rst_n !== ~exp) begin
      failures++;
      $display("FAIL %s: act sys_rst=%0b sys_rst_n=%0b, exp %0b/%0b",
               tag, sys_rst, sys_rst_n, exp, ~exp);
    end
  endtask

  // release the power-fail cause right after a tick and expect the stretch
  task automatic release_pf(input string tag);
    wait_tick();
    pwr_fail = 1'b0;
    mark = tick_seen;
    push(1'b0, HOLD, tag);
  endtask

  initial begin
    rst_n = 1'b0; pwr_fail = 1'b0; btn_n = 1'b1; strobe = 1'b0; wd_sel = 2'b00;
    repeat (6) @(negedge clk);
    chk_level(1'b1, "R1 reset state");

    // power-on stretch, then watchdog expiry and restart (sel 00)
    wait_tick();
    rst_n = 1'b1;
    mark = tick_seen;
    push(1'b0, HOLD, "R2 power-on stretch");
    push(1'b1, WD0,  "R6 watchdog starts full at release");
    push(1'b0, HOLD, "R8 stretch after expiry");
    push(1'b1, WD0,  "R8 watchdog restarts after expiry");
    wait_empty();
    pwr_fail = 1'b1;

    // period selection
    wd_sel = 2'b01;
    wait_tick(2);
    chk_level(1'b1, "R2 held by power-fail");
    release_pf("R2 stretch after power-fail");
    push(1'b1, WD1, "R5 period code 01");
    wait_empty(); pwr_fail = 1'b1;

    wd_sel = 2'b10;
    release_pf("R2 stretch after power-fail");
    push(1'b1, WD2, "R5 period code 10");
    wait_empty(); pwr_fail = 1'b1;

    wd_sel = 2'b11;
    release_pf("R2 stretch after power-fail");
    push(1'b1, WD2, "R5 code 11 as long period");
    wait_empty(); pwr_fail = 1'b1;

    // falling strobe reloads
    wd_sel = 2'b00;
    release_pf("R2 stretch after power-fail");
    wait_empty();
    wait_tick(2); strobe = 1'b1;
    wait_tick(2); strobe = 1'b0;
    mark = tick_seen;
    push(1'b1, WD0, "R7 falling strobe reloads");
    wait_empty(); pwr_fail = 1'b1;

    // rising strobe ignored
    release_pf("R2 stretch after power-fail");
    push(1'b1, WD0, "R7 rising strobe ignored");
    while (exp_q.size() != 1) @(negedge clk);
    wait_tick(3); strobe = 1'b1;
    wait_empty(); pwr_fail = 1'b1;

    // strobe edges and a long wait during reset change nothing
    wait_tick(2); strobe = 1'b0;
    wait_tick(2); strobe = 1'b1;
    wait_tick(2); strobe = 1'b0;
    wait_tick(15);
    chk_level(1'b1, "R6 no expiry during reset");
    release_pf("R2 stretch after power-fail");
    push(1'b1, WD0, "R6 strobes in reset ignored");
    wait_empty(); pwr_fail = 1'b1;

    // pushbutton: short press ignored, long press resets, release stretch
    release_pf("R2 stretch after power-fail");
    wait_empty();
    btn_n = 1'b0;
    wait_tick(2); btn_n = 1'b1;
    wait_tick(1);
    chk_level(1'b0, "R3 short press ignored");
    btn_n = 1'b0;
    mark = tick_seen;
    push(1'b1, DEB, "R3 debounced press");
    wait_empty();
    wait_tick(4);
    chk_level(1'b1, "R3 held while pressed");
    btn_n = 1'b1;
    mark = tick_seen;
    push(1'b0, DEB + HOLD, "R4 release debounce plus stretch");
    push(1'b1, WD0, "R6 watchdog after button reset");
    wait_empty(); pwr_fail = 1'b1;

    // new cause during the stretch restarts it
    wait_tick();
    pwr_fail = 1'b0;
    wait_tick(4);
    chk_level(1'b1, "R9 mid-stretch");
    pwr_fail = 1'b1;
    wait_tick();
    pwr_fail = 1'b0;
    mark = tick_seen;
    push(1'b0, HOLD, "R9 stretch restarted by new cause");
    push(1'b1, WD0, "R8 expiry after restarted stretch");
    wait_empty();
    pwr_fail = 1'b1;
    wait_tick(2);

    checks++;
    if (comp_bad != 0) begin
      failures++;
      $display("FAIL R1 complement: act bad cycles=%0d, exp 0", comp_bad);
    end
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R8 missing edges: act pending=%0d, exp 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule